// File: doc/BRIEF.md
# Relative branch and link unit

This block computes the program-counter update for a branch instruction on a 32-bit processor. Each request carries the low 28 bits of an instruction word, the address of that instruction, and a flag from the upstream condition evaluator saying whether the instruction's condition holds. The block decodes the word as a relative branch with an optional link. It then returns the next PC, a taken strobe, and a write to the return-address register when the call form is taken.

The branch word holds a 24-bit signed word offset in bits 23:0. The offset is relative to the running PC, not an absolute address. It is scaled by four and sign-extended to 32 bits, which gives a reach of about ±32 MB. The running PC is the instruction address plus 8, which models a fetch-ahead of two instructions. Bit 24 selects the call form: when it is set and the branch is taken, the address of the next sequential instruction (instruction address plus 4) goes to the return-address register, so that a later copy back to the PC returns to the caller. A failed condition, or a word whose bits 27:25 are not the branch class 3'b101, falls through to the instruction address plus 4.

Requests and results are valid/ready streams. A request is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its result is registered and shown on the following cycle. The result is held unchanged while `out_valid` is high and `out_ready` is low. During that time `in_ready` is low, so back-pressure from the consumer reaches the producer in the same cycle.

Top module: `brl_unit`

## Requirements
- R1: After reset, `out_valid`, `out_taken` and `out_link_we` are 0 and `in_ready` is 1.
- R2: A taken branch gives `out_next_pc` = pc + 8 + sign-extended(offset × 4), with the offset in instruction bits 23:0.
- R3: A taken branch with bit 24 set gives `out_link_we` = 1 and `out_link_data` = pc + 4.
- R4: A taken branch with bit 24 clear gives `out_link_we` = 0.
- R5: When `in_cond_pass` is 0, the result has `out_taken` = 0, `out_link_we` = 0 and `out_next_pc` = pc + 4.
- R6: A word whose bits 27:25 differ from 3'b101 is not a branch: `out_taken` = 0, `out_link_we` = 0, `out_next_pc` = pc + 4.
- R7: A request accepted at one rising edge shows its result with `out_valid` = 1 after that same edge, and each accepted request produces exactly one result.
- R8: While `out_valid` is 1 and `out_ready` is 0, the result fields stay unchanged, `in_ready` is 0, and a request offered at the input is not taken.
- R9: `in_ready` is 1 exactly when `out_valid` is 0 or `out_ready` is 1, so a result can be consumed and a new request accepted at the same edge.
- R10: Target arithmetic wraps modulo 2^32, in both the forward and the backward direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can accept a request |
| in_instr | input | 28 | Instruction bits 27:0: class in 27:25, link flag in 24, word offset in 23:0 |
| in_pc | input | 32 | Address of the instruction |
| in_cond_pass | input | 1 | Condition of the instruction holds |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_next_pc | output | 32 | Next program counter |
| out_taken | output | 1 | Branch taken |
| out_link_we | output | 1 | Write return address |
| out_link_data | output | 32 | Return address (pc + 4) |

## Verification
The assertions assume that the consumer drives `out_ready` as a plain level, and that a producer facing a low `in_ready` simply retries on a later cycle. The bench meets this by changing every input only on falling edges. It offers new words during stalls on purpose, and holds nothing from the block's outputs. The assertions also assume that `in_cond_pass` means something only alongside a valid request. For that reason the stimulus sets the condition flag together with each request and never relies on it while the input is idle.

// File: rtl/brl_pkg.sv
package brl_pkg;
  // Width of the instruction slice delivered to the unit (condition nibble excluded)
  localparam int INSN_W    = 28;
  // Position of the class field decoded by this unit
  localparam int CLASS_HI  = 27;
  localparam int CLASS_LO  = 25;
  localparam int CLASS_W   = CLASS_HI - CLASS_LO + 1;
  localparam logic [CLASS_W-1:0] BRANCH_CLASS = 3'b101;
  // Position of the call (link) flag
  localparam int LINK_POS  = 24;

  typedef struct packed {
    logic is_branch;
    logic want_link;
  } brl_kind_t;
endpackage

// File: rtl/brl_decode.sv
module brl_decode
  import brl_pkg::*;
#(
  parameter int OFF_W = 24
) (
  input  logic [INSN_W-1:0] insn,
  output brl_kind_t         kind,
  output logic [OFF_W-1:0]  word_off
);
  always_comb begin
    kind.is_branch = (insn[CLASS_HI:CLASS_LO] == BRANCH_CLASS);
    kind.want_link = insn[LINK_POS];
    word_off       = insn[OFF_W-1:0];
  end
endmodule

// File: rtl/brl_target.sv
module brl_target #(
  parameter int ADDR_W      = 32,
  parameter int OFF_W       = 24,
  parameter int ALIGN_SH    = 2,
  parameter int FETCH_AHEAD = 8,
  parameter int INSN_BYTES  = 4
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [OFF_W-1:0]  word_off,
  output logic [ADDR_W-1:0] jump_pc,
  output logic [ADDR_W-1:0] seq_pc
);
  localparam int EXT_W = ADDR_W - OFF_W - ALIGN_SH;
  localparam logic [ADDR_W-1:0] AHEAD = ADDR_W'(FETCH_AHEAD);
  localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(INSN_BYTES);

  logic [ADDR_W-1:0] byte_off;

  generate
    if (EXT_W > 0) begin : g_extend
      assign byte_off = {{EXT_W{word_off[OFF_W-1]}}, word_off, {ALIGN_SH{1'b0}}};
    end else begin : g_truncate
      logic [OFF_W+ALIGN_SH-1:0] scaled;
      assign scaled   = {word_off, {ALIGN_SH{1'b0}}};
      assign byte_off = scaled[ADDR_W-1:0];
    end
  endgenerate

  // Modulo 2^ADDR_W by width of the sum
  assign jump_pc = pc + AHEAD + byte_off;
  assign seq_pc  = pc + STEP;
endmodule

// File: rtl/brl_outreg.sv
module brl_outreg #(
  parameter int W = 66
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  // R8: a stalled result keeps its value
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R7: an accepted request is presented on the next cycle
  a_r7_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R7: with no request accepted and the result drained, the output empties
  a_r7_drain_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);
endmodule

// File: rtl/brl_unit.sv
module brl_unit
  import brl_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int OFF_W       = 24,
  parameter int ALIGN_SH    = 2,
  parameter int FETCH_AHEAD = 8,
  parameter int INSN_BYTES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [INSN_W-1:0] in_instr,
  input  logic [ADDR_W-1:0] in_pc,
  input  logic              in_cond_pass,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_next_pc,
  output logic              out_taken,
  output logic              out_link_we,
  output logic [ADDR_W-1:0] out_link_data
);
  localparam int RES_W = 2 * ADDR_W + 2;

  brl_kind_t         kind;
  logic [OFF_W-1:0]  word_off;
  logic [ADDR_W-1:0] jump_pc, seq_pc;
  logic              take, link_wr;
  logic [RES_W-1:0]  res_in, res_out;

  brl_decode #(.OFF_W(OFF_W)) u_dec (
    .insn     (in_instr),
    .kind     (kind),
    .word_off (word_off)
  );

  brl_target #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .ALIGN_SH(ALIGN_SH),
    .FETCH_AHEAD(FETCH_AHEAD), .INSN_BYTES(INSN_BYTES)
  ) u_tgt (
    .pc       (in_pc),
    .word_off (word_off),
    .jump_pc  (jump_pc),
    .seq_pc   (seq_pc)
  );

  always_comb begin
    take    = kind.is_branch && in_cond_pass;
    link_wr = take && kind.want_link;
    res_in  = {(take ? jump_pc : seq_pc), take, link_wr, seq_pc};
  end

  brl_outreg #(.W(RES_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (res_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (res_out)
  );

  assign {out_next_pc, out_taken, out_link_we, out_link_data} = res_out;

  // R3: the return-address write only accompanies a taken branch
  a_r3_link_needs_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_link_we) |-> out_taken);

  // R5: fall-through PC equals the sequential return address
  a_r5_fallthrough_seq: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_taken) |-> (out_next_pc == out_link_data));

  // R4: plain branch writes no return address
  a_r4_plain_no_link: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_instr[LINK_POS]) |=> !out_link_we);

  // R5: failed condition is never taken
  a_r5_cond_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_cond_pass) |=> (!out_taken && !out_link_we));
endmodule

// File: tb/sim_brl_unit.sv
`timescale 1ns/1ps
module sim_brl_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [27:0] in_instr = '0;
  logic [31:0] in_pc = '0;
  logic        in_cond_pass = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_next_pc;
  logic        out_taken;
  logic        out_link_we;
  logic [31:0] out_link_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  brl_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_pc(in_pc), .in_cond_pass(in_cond_pass),
    .out_valid(out_valid), .out_ready(out_ready), .out_next_pc(out_next_pc),
    .out_taken(out_taken), .out_link_we(out_link_we), .out_link_data(out_link_data)
  );

  localparam int NV = 9;
  // stimulus: pc, instruction (low 28 bits), condition
  localparam logic [31:0] V_PC [NV] = '{
    32'h0000_1000, 32'h0000_2000, 32'h0000_3000, 32'hFFFF_FFF0, 32'h0000_0000,
    32'h0000_4000, 32'h0000_0100, 32'h0300_0000, 32'h0000_5000};
  localparam logic [27:0] V_IN [NV] = '{
    28'hA00_0010, 28'hBFF_FFFE, 28'hB00_0001, 28'hA00_0004, 28'hAFF_FFFC,
    28'h000_0001, 28'hA7F_FFFF, 28'hB80_0000, 28'hE00_0000};
  localparam logic V_CP [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
  // expected: next pc, taken, link write, link data
  localparam logic [31:0] E_NPC [NV] = '{
    32'h0000_1048, 32'h0000_2000, 32'h0000_3004, 32'h0000_0008, 32'hFFFF_FFF8,
    32'h0000_4004, 32'h0200_0104, 32'h0100_0008, 32'h0000_5004};
  localparam logic E_TK [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam logic E_WE [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
  localparam logic [31:0] E_LD [NV] = '{
    32'h0000_1004, 32'h0000_2004, 32'h0000_3004, 32'hFFFF_FFF4, 32'h0000_0004,
    32'h0000_4004, 32'h0000_0104, 32'h0300_0004, 32'h0000_5004};
  // requirement each vector mainly targets
  localparam string V_REQ [NV] = '{"R2", "R3", "R5", "R10", "R10", "R6", "R2", "R3", "R6"};

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] pc, input logic [27:0] insn, input logic cp);
    in_pc = pc; in_instr = insn; in_cond_pass = cp; in_valid = 1'b1;
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    chk("R1", "out_valid in reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "out_valid", 32'(out_valid), 32'd0);
    chk("R1", "out_taken", 32'(out_taken), 32'd0);
    chk("R1", "out_link_we", 32'(out_link_we), 32'd0);
    chk("R1", "in_ready", 32'(in_ready), 32'd1);

    // table walk, consumer always ready
    for (int i = 0; i < NV; i++) begin
      drive(V_PC[i], V_IN[i], V_CP[i]);
      @(negedge clk);
      in_valid = 1'b0;
      chk("R7", "out_valid", 32'(out_valid), 32'd1);
      chk(V_REQ[i], "next_pc", out_next_pc, E_NPC[i]);
      chk(V_REQ[i], "taken", 32'(out_taken), 32'(E_TK[i]));
      chk(E_WE[i] ? "R3" : "R4", "link_we", 32'(out_link_we), 32'(E_WE[i]));
      chk("R3", "link_data", out_link_data, E_LD[i]);
    end
    @(negedge clk);
    chk("R7", "drained out_valid", 32'(out_valid), 32'd0);

    // R8/R9: back-pressure
    out_ready = 1'b0;
    drive(32'h0000_1000, 28'hA00_0010, 1'b1);
    @(negedge clk);
    chk("R9", "in_ready stalled", 32'(in_ready), 32'd0);
    drive(32'h0000_2000, 28'hBFF_FFFE, 1'b1);   // offered during stall
    repeat (2) @(negedge clk);
    chk("R8", "held next_pc", out_next_pc, 32'h0000_1048);
    chk("R8", "held link_we", 32'(out_link_we), 32'd0);
    chk("R8", "held valid", 32'(out_valid), 32'd1);
    chk("R8", "in_ready still low", 32'(in_ready), 32'd0);
    out_ready = 1'b1;
    #1;
    chk("R9", "in_ready on drain", 32'(in_ready), 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9", "swap next_pc", out_next_pc, 32'h0000_2000);
    chk("R9", "swap link_we", 32'(out_link_we), 32'd1);
    @(negedge clk);
    chk("R7", "one result per request", 32'(out_valid), 32'd0);

    // R7: back-to-back requests, one per cycle
    drive(32'h0000_0100, 28'hA7F_FFFF, 1'b1);
    @(negedge clk);
    chk("R7", "b2b first", out_next_pc, 32'h0200_0104);
    drive(32'h0300_0000, 28'hB80_0000, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R5", "b2b second fall-through", out_next_pc, 32'h0300_0004);
    chk("R5", "b2b second link_we", 32'(out_link_we), 32'd0);

    // R1: reset mid-run clears result
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "valid after reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule